// File: doc/BRIEF.md
# Stepwise AES-128 Round-Key Generator

This block turns a 128-bit AES cipher key into the eleven round keys of AES-128, one round key at a time. It never holds the whole 44-word schedule. Only the current round key is kept, together with a round counter and the current round constant. Each new round key is derived from that state when a consumer asks for it.

A cipher datapath loads the key with a one-cycle strobe and uses round key 0 at once. It then raises a step request each time it needs the following round key and waits for the valid flag to return.

A small state machine sequences the work:
- **IDLE**: the state after reset. No key is present.
- **READY**: a round key is presented and valid.
- **CALC**: one 32-bit word of the new key is written per cycle, so this state lasts four cycles.
- **DONE**: round key 10 is presented and held.

The transitions are:
- **LOAD**: from any state to READY when the load strobe is high.
- **STEP**: from READY to CALC on a step request.
- **WORDS_DONE**: from CALC back to READY after the fourth word.
- **FINAL**: from CALC to DONE when the round just finished is round 10.

Top module: `aes128_rkey_stepper`

## Requirements
- R1: After reset the valid flag is 0, the round index is 0 and the round-key output is all zeros.
- R2: A load strobe high at a clock edge makes the next cycle show the loaded key on the round-key output, with round index 0 and valid 1. The load is taken in every state, including during CALC, and it takes priority over a step request in the same cycle.
- R3: A step request at an edge where valid is 1, the round index is below 10 and load is low drops valid in the next cycle. Valid stays low for exactly four cycles and returns high at the fourth edge after the request edge, with the round index raised by one.
- R4: Word 0 of a new round key is word 0 of the old key XOR SubWord(RotWord(old word 3)) XOR the round word. Word 0 sits in bits 127:96 and word 3 in bits 31:0. Within a word, byte 0 is the most significant byte. RotWord turns bytes [a0,a1,a2,a3] into [a1,a2,a3,a0]. The round word has the round constant in byte 0 and zeros in the other bytes.
- R5: For j = 1, 2, 3, word j of the new key is old word j XOR new word j-1.
- R6: The round constant used when producing round key r (r = 1..10) is, in hex, 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. Each value is the previous one multiplied by x in GF(2^8), reduced by 0x11b.
- R7: SubWord replaces each byte by the AES S-box value. That value is the multiplicative inverse modulo x^8+x^4+x^3+x+1, with 0 mapping to 0, followed by the affine map b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R8: Once round 10 is presented, valid stays 1, the round index stays 10 and the key stays unchanged until the next load. Step requests have no effect in this state.
- R9: A step request while valid is 0 (in IDLE or in CALC) has no effect: no extra round is computed.
- R10: Cipher key 2b7e151628aed2a6abf7158809cf4f3c yields round key 10 d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for the cipher key |
| key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| next_i | input | 1 | Request for the following round key |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the presented round key (0..10) |
| valid_o | output | 1 | Round key on rkey_o is complete |

## Verification
The hardest situations to reach from the ports are step and load requests that arrive in the middle of a four-cycle CALC pass. During that pass the key register holds a half-updated key and the round counter has not yet moved. The bench forces these cases by sending a step pulse on every cycle of a pass and by loading a new key two cycles into a pass. It then checks the final round index and the resulting key against its own reference model. Random keys with random gaps between step requests cover the full eleven-key sequence many times over, including the terminal hold at round 10.

// File: rtl/aes128_ks_pkg.sv
package aes128_ks_pkg;

    localparam int KEY_W      = 128;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_WORDS  = KEY_W / WORD_W;
    localparam int WSEL_W     = $clog2(NUM_WORDS);
    localparam int LAST_ROUND = 10;
    localparam int RND_W      = $clog2(LAST_ROUND + 1);
    localparam logic [BYTE_W-1:0] FIELD_POLY = 8'h1b;
    localparam logic [BYTE_W-1:0] AFFINE_C   = 8'h63;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READY = 2'd1,
        S_CALC  = 2'd2,
        S_DONE  = 2'd3
    } ks_state_e;

    function automatic logic [BYTE_W-1:0] gf_xtime(input logic [BYTE_W-1:0] a);
        gf_xtime = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_POLY : '0);
    endfunction

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        gf_mul = acc;
    endfunction

    function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] a, input int n);
        rotl8 = (a << n) | (a >> (BYTE_W - n));
    endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
    import aes128_ks_pkg::*;
(
    input  logic [BYTE_W-1:0] in_b,
    output logic [BYTE_W-1:0] out_b
);

    logic [BYTE_W-1:0] inv_b;

    // x^254 equals the inverse for nonzero x and 0 for x = 0
    always_comb begin
        logic [BYTE_W-1:0] pw;
        logic [BYTE_W-1:0] acc;
        pw  = in_b;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        inv_b = acc;
    end

    assign out_b = inv_b ^ rotl8(inv_b, 1) ^ rotl8(inv_b, 2)
                 ^ rotl8(inv_b, 3) ^ rotl8(inv_b, 4) ^ AFFINE_C;

endmodule

// File: rtl/ks_subword.sv
module ks_subword
    import aes128_ks_pkg::*;
(
    input  logic [WORD_W-1:0] in_w,
    output logic [WORD_W-1:0] out_w
);

    localparam int NBYTES = WORD_W / BYTE_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        ks_sbox u_sbox (
            .in_b  (in_w [g*BYTE_W +: BYTE_W]),
            .out_b (out_w[g*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
    import aes128_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              next_i,
    output logic              wr_en_o,
    output logic [WSEL_W-1:0] wsel_o,
    output logic              round_end_o,
    output logic [RND_W-1:0]  round_o,
    output logic              valid_o
);

    ks_state_e         state_q, state_d;
    logic [WSEL_W-1:0] wcnt_q, wcnt_d;
    logic [RND_W-1:0]  round_q, round_d;
    logic              last_word;

    assign last_word = (wcnt_q == WSEL_W'(NUM_WORDS - 1));

    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        round_d = round_q;
        if (load_i) begin
            state_d = S_READY;             // LOAD
            wcnt_d  = '0;
            round_d = '0;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_READY: begin
                    if (next_i) begin
                        state_d = S_CALC;  // STEP
                        wcnt_d  = '0;
                    end
                end
                S_CALC: begin
                    wcnt_d = wcnt_q + 1'b1;
                    if (last_word) begin
                        round_d = round_q + 1'b1;
                        state_d = (round_q == RND_W'(LAST_ROUND - 1)) ? S_DONE   // FINAL
                                                                      : S_READY; // WORDS_DONE
                    end
                end
                S_DONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wcnt_q  <= '0;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            round_q <= round_d;
        end
    end

    always_comb begin
        valid_o     = 1'b0;
        wr_en_o     = 1'b0;
        round_end_o = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_READY: valid_o = 1'b1;
            S_CALC: begin
                wr_en_o     = 1'b1;
                round_end_o = last_word;
            end
            S_DONE:  valid_o = 1'b1;
        endcase
    end
    assign wsel_o  = wcnt_q;
    assign round_o = round_q;

    // R9: a step request in IDLE does not leave IDLE
    a_r9_idle_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !load_i) |=> (state_q == S_IDLE));

    // R3: round index never passes the last round
    a_r3_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
        round_q <= RND_W'(LAST_ROUND));

    // R9: a CALC pass is not restarted by step requests
    a_r9_calc_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CALC && !last_word && !load_i) |=>
            (state_q == S_CALC && wcnt_q == $past(wcnt_q) + 1'b1));

endmodule

// File: rtl/aes128_rkey_stepper.sv
module aes128_rkey_stepper
    import aes128_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             next_i,
    output logic [KEY_W-1:0] rkey_o,
    output logic [RND_W-1:0] round_o,
    output logic             valid_o
);

    logic [WORD_W-1:0] w_q [NUM_WORDS];
    logic [BYTE_W-1:0] rcon_q;
    logic              wr_en;
    logic [WSEL_W-1:0] wsel;
    logic              round_end;
    logic [WORD_W-1:0] rot_w, sub_w, chain_w, new_w;

    ks_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .next_i      (next_i),
        .wr_en_o     (wr_en),
        .wsel_o      (wsel),
        .round_end_o (round_end),
        .round_o     (round_o),
        .valid_o     (valid_o)
    );

    // RotWord: bytes move one place toward the most significant end
    assign rot_w = {w_q[NUM_WORDS-1][WORD_W-BYTE_W-1:0],
                    w_q[NUM_WORDS-1][WORD_W-1 -: BYTE_W]};

    ks_subword u_subword (
        .in_w  (rot_w),
        .out_w (sub_w)
    );

    always_comb begin
        if (wsel == '0)
            chain_w = sub_w ^ {rcon_q, {(WORD_W-BYTE_W){1'b0}}};
        else
            chain_w = w_q[wsel - 1'b1];
    end
    assign new_w = w_q[wsel] ^ chain_w;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                w_q[g] <= '0;
            else if (load_i)
                w_q[g] <= key_i[KEY_W-1-g*WORD_W -: WORD_W];
            else if (wr_en && wsel == WSEL_W'(g))
                w_q[g] <= new_w;
        end
        assign rkey_o[KEY_W-1-g*WORD_W -: WORD_W] = w_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rcon_q <= 8'h01;
        else if (load_i)
            rcon_q <= 8'h01;
        else if (round_end)
            rcon_q <= gf_xtime(rcon_q);
    end

    // R2: a load presents the cipher key as round 0
    a_r2_load_presents_key: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && round_o == '0 && rkey_o == $past(key_i)));

    // R3: a granted step drops valid at once
    a_r3_step_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && next_i && !load_i && round_o < RND_W'(LAST_ROUND)) |=> !valid_o);

    // R3: valid returning without a load comes with a round increment
    a_r3_valid_return_increments: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid_o) && !$past(load_i)) |-> (round_o == $past(round_o) + 1'b1));

    // R8: round 10 is held with a stable key until a load
    a_r8_terminal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && round_o == RND_W'(LAST_ROUND) && !load_i) |=>
            (valid_o && round_o == RND_W'(LAST_ROUND) && $stable(rkey_o)));

    // R2: a valid key without load or step stays put
    a_r2_valid_key_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !load_i && !next_i) |=> (valid_o && $stable(rkey_o) && $stable(round_o)));

endmodule

// File: tb/test_aes128_rkey_stepper.sv
module test_aes128_rkey_stepper;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [127:0] key_i = '0;
    logic         next_i = 1'b0;
    logic [127:0] rkey_o;
    logic [3:0]   round_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    aes128_rkey_stepper i_aes128_rkey_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .key_i   (key_i),
        .next_i  (next_i),
        .rkey_o  (rkey_o),
        .round_o (round_o),
        .valid_o (valid_o)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv;
        logic [7:0] r;
        inv = 8'h00;
        for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
                 ^ 8'h63 >> i;
        return r;
    endfunction

    function automatic logic [7:0] m_rcon(input int r);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < r; i++) c = m_mul(c, 8'h02);
        return c;
    endfunction

    function automatic logic [127:0] m_next(input logic [127:0] k, input int r);
        logic [31:0] w0, w1, w2, w3, t;
        w0 = k[127:96]; w1 = k[95:64]; w2 = k[63:32]; w3 = k[31:0];
        t  = {w3[23:0], w3[31:24]};
        t  = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
        t  = t ^ {m_rcon(r), 24'h0};
        w0 = w0 ^ t; w1 = w1 ^ w0; w2 = w2 ^ w1; w3 = w3 ^ w2;
        return {w0, w1, w2, w3};
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] k);
        load_i = 1'b1; key_i = k;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // request one step and check the valid timing; returns after valid is back
    task automatic do_step(input int exp_round, input logic [127:0] exp_key);
        int lows;
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
        lows = 0;
        for (int i = 0; i < 4; i++) begin
            if (!valid_o) lows++;
            @(negedge clk);
        end
        check(lows == 4 && valid_o, "R3 valid low four cycles", 128'(lows), 128'd4);
        check(round_o == 4'(exp_round), "R3 round index", 128'(round_o), 128'(exp_round));
        check(rkey_o == exp_key, "R4/R5/R6/R7 round key", rkey_o, exp_key);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [127:0] k, ref_k, held;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!valid_o && round_o == 0 && rkey_o == '0, "R1 reset state",
              {rkey_o[126:0], valid_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: step while idle has no effect
        next_i = 1'b1;
        repeat (3) @(negedge clk);
        next_i = 1'b0;
        repeat (5) @(negedge clk);
        check(!valid_o && round_o == 0, "R9 step ignored in IDLE", 128'(round_o), 128'd0);

        // R10 standard vector with per-round checks
        k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        do_load(k);
        check(valid_o && round_o == 0 && rkey_o == k, "R2 load presents key", rkey_o, k);
        ref_k = k;
        for (int r = 1; r <= 10; r++) begin
            ref_k = m_next(ref_k, r);
            do_step(r, ref_k);
        end
        check(rkey_o == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R10 standard round 10 key",
              rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        check(m_rcon(9) == 8'h1b && m_rcon(10) == 8'h36, "R6 model constants",
              128'(m_rcon(10)), 128'h36);

        // R8: terminal hold, steps ignored
        held = rkey_o;
        next_i = 1'b1;
        repeat (6) @(negedge clk);
        next_i = 1'b0;
        @(negedge clk);
        check(valid_o && round_o == 10 && rkey_o == held, "R8 round 10 held", rkey_o, held);

        // R9: step pulses during CALC do not add rounds
        k = {$urandom, $urandom, $urandom, $urandom};
        do_load(k);
        next_i = 1'b1;
        repeat (4) @(negedge clk);   // request edge plus three CALC edges
        next_i = 1'b0;
        @(negedge clk);
        check(valid_o && round_o == 1, "R9 steps in CALC ignored", 128'(round_o), 128'd1);
        repeat (6) @(negedge clk);
        check(valid_o && round_o == 1 && rkey_o == m_next(k, 1), "R9 no extra round",
              rkey_o, m_next(k, 1));

        // R2: load in the middle of CALC wins
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
        @(negedge clk);
        k = {$urandom, $urandom, $urandom, $urandom};
        load_i = 1'b1; key_i = k; next_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; next_i = 1'b0;
        check(valid_o && round_o == 0 && rkey_o == k, "R2 load during CALC", rkey_o, k);
        repeat (5) @(negedge clk);
        check(valid_o && round_o == 0 && rkey_o == k, "R2 stays at round 0", rkey_o, k);

        // random keys, random gaps, corner keys first
        for (int n = 0; n < 14; n++) begin
            if (n == 0)      k = '0;
            else if (n == 1) k = '1;
            else             k = {$urandom, $urandom, $urandom, $urandom};
            do_load(k);
            check(valid_o && round_o == 0 && rkey_o == k, "R2 random load", rkey_o, k);
            ref_k = k;
            for (int r = 1; r <= 10; r++) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                ref_k = m_next(ref_k, r);
                do_step(r, ref_k);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule